// File: doc/BRIEF.md
# Pipelined Exception Flush Controller

This block makes exceptions precise in a five-stage in-order pipeline whose stages are fetch, decode, execute, memory and writeback. Fetch, decode, execute and memory each present three things for the instruction they hold: a valid bit, an exception flag and a 5-bit reason code, along with that instruction's PC. Writeback cannot fault, so it has no input here.

In every cycle the controller looks for the oldest stage that holds a valid instruction with a raised flag. If it finds one, it does three things in that same cycle. It asserts flush for that stage and for every younger stage, so the datapath turns those slots into bubbles that never write registers or memory. It leaves every older stage running. It asks the fetch unit to load a fixed handler address, which takes effect at the next edge.

At that same edge the faulting instruction's PC is stored in an exception-PC register. A 32-bit cause word that carries the reason code is stored beside it. A move-from-coprocessor instruction reads either register through a small combinational read port, so software can later return with a register jump.

Top module: `exc_flush_ctrl`

## Requirements
- R1: A cycle with `rst_n` low clears the exception PC and the cause word to zero at that clock edge.
- R2: A raised exception flag is ignored when that stage's valid bit is 0. Such a flag causes no flush and no redirect, and leaves both registers unchanged.
- R3: When several valid stages raise flags in the same cycle, the oldest one is taken. Stage index 3 (memory) has the highest priority, then 2 (execute), then 1 (decode), then 0 (fetch). The flags of the younger stages are discarded.
- R4: In the cycle an exception is taken from stage index k, `flush_o[i]` is 1 for every i ≤ k and 0 for every i > k. With no exception taken, `flush_o` is all zero. Bit 0 is fetch, bit 1 decode, bit 2 execute and bit 3 memory.
- R5: `redirect_o` is 1 exactly in the cycle an exception is taken. `redirect_pc_o` always equals the parameter `HANDLER_ADDR`, so the handler is fetched in the following cycle.
- R6: At the clock edge that ends the taking cycle, the exception PC is loaded with the PC of the chosen stage, which is the faulting instruction itself.
- R7: At that same edge the cause word is loaded with the chosen stage's code in bits [6:2], with all other bits zero. The codes are 0x01 fetch page fault, 0x02 data page fault, 0x04 address error, 0x08 syscall, 0x0A undefined opcode, 0x0C overflow and 0x0D divide by zero.
- R8: The exception PC and the cause word keep their values in every cycle in which no exception is taken.
- R9: `rd_data_o` shows the exception PC when `rd_sel_i` is 0 and the cause word when `rd_sel_i` is 1. The read is combinational and returns the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stg_valid_i | input | 4 | Per-stage valid bit (0 fetch .. 3 memory) |
| stg_exc_i | input | 4 | Per-stage exception flag |
| stg_code_i | input | 20 | Per-stage 5-bit reason code; stage i uses bits [5i+4:5i] |
| stg_pc_i | input | 128 | Per-stage instruction PC; stage i uses bits [32i+31:32i] |
| rd_sel_i | input | 1 | Read select: 0 exception PC, 1 cause word |
| flush_o | output | 4 | Per-stage flush request, active in the detection cycle |
| redirect_o | output | 1 | Fetch PC must load the handler address at the next edge |
| redirect_pc_o | output | 32 | Handler address |
| rd_data_o | output | 32 | Read port data |

## Verification
The bench sweeps all 256 combinations of the four valid bits and the four exception flags. For each combination it derives a different PC for every stage and a code for every stage from the combination number.

Patterns with a single raised valid flag show whether each stage's flush boundary and captured PC are correct. Patterns with several raised flags show whether priority really follows age. Patterns whose only flags sit on invalid stages show whether bubbles are filtered out. Patterns without an exception taken show that the registers hold their values.

Both halves of the read port are read after every cycle. A reset in the middle of the run shows that the registers clear.

// File: rtl/exc_pkg.sv
// Package: shared constants for the exception flush controller.
// Assumes stage index 0 is the youngest stage (fetch) and rises with age.
package exc_pkg;

    localparam int unsigned CODE_W   = 5;   // width of a reason code
    localparam int unsigned CAUSE_W  = 32;  // width of the cause word
    localparam int unsigned CODE_LSB = 2;   // position of the code in the cause word

    // Reason codes carried in the cause word
    typedef enum logic [CODE_W-1:0] {
        EXC_FETCH_PF = 5'h01,
        EXC_DATA_PF  = 5'h02,
        EXC_ADDR_ERR = 5'h04,
        EXC_SYSCALL  = 5'h08,
        EXC_UNDEF_OP = 5'h0A,
        EXC_OVERFLOW = 5'h0C,
        EXC_DIV_ZERO = 5'h0D
    } exc_code_e;

    // Stage indices in program-age order
    typedef enum logic [1:0] {
        STG_FETCH  = 2'd0,
        STG_DECODE = 2'd1,
        STG_EXEC   = 2'd2,
        STG_MEMORY = 2'd3
    } stage_e;

endpackage

// File: rtl/exc_oldest_pick.sv
// Module: exc_oldest_pick
// Picks the oldest stage holding a valid instruction with a raised
// exception flag, and returns its index, reason code and PC.
// Assumes a higher stage index means an older instruction.
module exc_oldest_pick #(
    parameter int NUM_STG = 4,
    parameter int PC_W    = 32,
    parameter int CODE_W  = 5,
    parameter int IDX_W   = $clog2(NUM_STG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_STG-1:0]        valid_i,
    input  logic [NUM_STG-1:0]        exc_i,
    input  logic [NUM_STG*CODE_W-1:0] code_i,
    input  logic [NUM_STG*PC_W-1:0]   pc_i,
    output logic                      take_o,
    output logic [IDX_W-1:0]          idx_o,
    output logic [CODE_W-1:0]         code_o,
    output logic [PC_W-1:0]           pc_o
);

    logic [NUM_STG-1:0] raised;
    logic [CODE_W-1:0]  lane_code [NUM_STG];
    logic [PC_W-1:0]    lane_pc   [NUM_STG];

    // Unpack each stage's lane and qualify its flag with valid
    for (genvar gi = 0; gi < NUM_STG; gi++) begin : g_lane
        assign raised[gi]    = valid_i[gi] & exc_i[gi];
        assign lane_code[gi] = code_i[gi*CODE_W +: CODE_W];
        assign lane_pc[gi]   = pc_i[gi*PC_W +: PC_W];
    end

    // Scan from youngest to oldest; a later (older) hit overrides an earlier one
    always_comb begin
        take_o = 1'b0;
        idx_o  = '0;
        code_o = '0;
        pc_o   = '0;
        for (int i = 0; i < NUM_STG; i++) begin
            if (raised[i]) begin
                take_o = 1'b1;
                idx_o  = IDX_W'(i);
                code_o = lane_code[i];
                pc_o   = lane_pc[i];
            end
        end
    end

    AST_TAKE_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (valid_i[idx_o] && exc_i[idx_o]));                       // R2
    AST_NO_OLDER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (((raised >> idx_o) >> 1) == '0));                       // R3
    AST_IDLE_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid_i & exc_i) == '0) |-> !take_o);                             // R2

endmodule

// File: rtl/exc_flush_mask.sv
// Module: exc_flush_mask
// Builds the per-stage flush vector: the chosen stage and every younger
// stage are flushed, every older stage is left running.
// Assumes idx_i is meaningful only while take_i is high.
module exc_flush_mask #(
    parameter int NUM_STG = 4,
    parameter int IDX_W   = $clog2(NUM_STG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [NUM_STG-1:0] flush_o
);

    // One comparator per stage: flush when at or younger than the faulting stage
    for (genvar gi = 0; gi < NUM_STG; gi++) begin : g_flush
        assign flush_o[gi] = take_i && (IDX_W'(gi) <= idx_i);
    end

    AST_FLUSH_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o & (flush_o + 1'b1)) == '0);                                // R4
    AST_FLUSH_HITS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (flush_o[idx_i] && flush_o[0]));                         // R4
    AST_NO_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |-> (flush_o == '0));                                       // R4

endmodule

// File: rtl/exc_status_regs.sv
// Module: exc_status_regs
// Holds the exception PC and the cause word, loads both when an exception
// is taken, and drives a combinational read port for move-from reads.
// Assumes a synchronous active-low reset.
module exc_status_regs
    import exc_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int RD_W = (PC_W > int'(CAUSE_W)) ? PC_W : int'(CAUSE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic              rd_sel_i,
    output logic [RD_W-1:0]   rd_data_o
);

    logic [PC_W-1:0]    epc_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] cause_d;

    // Place the reason code into its field with all other bits zero
    always_comb begin
        cause_d = '0;
        cause_d[CODE_LSB +: CODE_W] = code_i;
    end

    // Load both registers on a taken exception, clear them on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (take_i) begin
            epc_q   <= pc_i;
            cause_q <= cause_d;
        end
    end

    // Read port selects the register for a move-from instruction
    always_comb begin
        if (rd_sel_i) rd_data_o = RD_W'(cause_q);
        else          rd_data_o = RD_W'(epc_q);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (epc_q == '0 && cause_q == '0));                         // R1
    AST_EPC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(epc_q));                                        // R8
    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(cause_q));                                      // R8

endmodule

// File: rtl/exc_flush_ctrl.sv
// Module: exc_flush_ctrl (top)
// Precise-exception controller for a five-stage in-order pipeline.
// Chooses the oldest faulting stage, flushes it and all younger stages,
// redirects fetch to HANDLER_ADDR and records the PC and cause.
// Assumes stage 0 = fetch .. 3 = memory; writeback never faults.
module exc_flush_ctrl
    import exc_pkg::*;
#(
    parameter int              NUM_STG      = 4,
    parameter int              PC_W         = 32,
    parameter logic [PC_W-1:0] HANDLER_ADDR = 32'h8000_0180,
    localparam int             IDX_W        = $clog2(NUM_STG),
    localparam int             RD_W         = (PC_W > int'(CAUSE_W)) ? PC_W : int'(CAUSE_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_STG-1:0]        stg_valid_i,
    input  logic [NUM_STG-1:0]        stg_exc_i,
    input  logic [NUM_STG*CODE_W-1:0] stg_code_i,
    input  logic [NUM_STG*PC_W-1:0]   stg_pc_i,
    input  logic                      rd_sel_i,
    output logic [NUM_STG-1:0]        flush_o,
    output logic                      redirect_o,
    output logic [PC_W-1:0]           redirect_pc_o,
    output logic [RD_W-1:0]           rd_data_o
);

    logic              take;
    logic [IDX_W-1:0]  sel_idx;
    logic [CODE_W-1:0] sel_code;
    logic [PC_W-1:0]   sel_pc;

    exc_oldest_pick #(
        .NUM_STG (NUM_STG),
        .PC_W    (PC_W),
        .CODE_W  (CODE_W),
        .IDX_W   (IDX_W)
    ) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (stg_valid_i),
        .exc_i   (stg_exc_i),
        .code_i  (stg_code_i),
        .pc_i    (stg_pc_i),
        .take_o  (take),
        .idx_o   (sel_idx),
        .code_o  (sel_code),
        .pc_o    (sel_pc)
    );

    exc_flush_mask #(
        .NUM_STG (NUM_STG),
        .IDX_W   (IDX_W)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .idx_i   (sel_idx),
        .flush_o (flush_o)
    );

    exc_status_regs #(
        .PC_W (PC_W),
        .RD_W (RD_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .code_i    (sel_code),
        .pc_i      (sel_pc),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o)
    );

    // Fetch redirect: the PC register loads the handler at the next edge
    assign redirect_o    = take;
    assign redirect_pc_o = HANDLER_ADDR;

    AST_REDIRECT_FLUSHES_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> flush_o[STG_FETCH]);                                 // R5
    AST_FLUSH_MEANS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o != '0) |-> redirect_o);                                    // R5

endmodule

// File: tb/sim_exc_flush_ctrl.sv
`timescale 1ns/100ps
module sim_exc_flush_ctrl;

    localparam logic [31:0] HANDLER = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  stg_valid_i = '0;
    logic [3:0]  stg_exc_i = '0;
    logic [19:0] stg_code_i = '0;
    logic [127:0] stg_pc_i = '0;
    logic        rd_sel_i = 1'b0;
    logic [3:0]  flush_o;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;
    logic [31:0] rd_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_epc;
    logic [31:0] m_cause;

    exc_flush_ctrl #(.HANDLER_ADDR(HANDLER)) u0 (
        .clk(clk), .rst_n(rst_n), .stg_valid_i(stg_valid_i), .stg_exc_i(stg_exc_i),
        .stg_code_i(stg_code_i), .stg_pc_i(stg_pc_i), .rd_sel_i(rd_sel_i),
        .flush_o(flush_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .rd_data_o(rd_data_o)
    );

    always #2 clk = ~clk;  // 250 MHz

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [4:0] code_of(input int s, input int c);
        case (s)
            0: return 5'h01;
            1: return c[0] ? 5'h08 : 5'h0A;
            2: return c[1] ? 5'h0D : 5'h0C;
            default: return c[2] ? 5'h04 : 5'h02;
        endcase
    endfunction

    function automatic logic [31:0] pc_of(input int s, input int c);
        return 32'h0000_4000 + 32'(c * 32) + 32'((3 - s) * 4);
    endfunction

    // Read both registers through the read port and compare with the model
    task automatic read_back(input string tag_epc, input string tag_cause);
        #0.5 rd_sel_i = 1'b0;
        #0.5 check(tag_epc, rd_data_o, m_epc);
        rd_sel_i = 1'b1;
        #0.5 check(tag_cause, rd_data_o, m_cause);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_epc = '0;
        m_cause = '0;
        // R1: reset state
        repeat (3) @(posedge clk);
        read_back("R1 epc after reset", "R1 cause after reset");
        @(negedge clk);
        #0.5 check("R1 flush idle", {28'd0, flush_o}, 32'd0);
        check("R1 redirect idle", {31'd0, redirect_o}, 32'd0);
        rst_n = 1'b1;

        // Exhaustive sweep over valid x flag patterns
        for (int c = 0; c < 256; c++) begin
            logic [3:0] v, e, r, exp_flush;
            int idx, n;
            bit tk;
            string tag;
            @(negedge clk);
            v = c[7:4];
            e = c[3:0];
            for (int s = 0; s < 4; s++) begin
                stg_code_i[s*5 +: 5] = code_of(s, c);
                stg_pc_i[s*32 +: 32] = pc_of(s, c);
            end
            stg_valid_i = v;
            stg_exc_i = e;
            r = v & e;
            tk = 1'b0; idx = 0; n = 0;
            for (int s = 0; s < 4; s++) if (r[s]) begin tk = 1'b1; idx = s; n++; end
            exp_flush = tk ? 4'((1 << (idx + 1)) - 1) : 4'd0;
            #0.5;
            check("R4 flush mask", {28'd0, flush_o}, {28'd0, exp_flush});
            check("R5 redirect", {31'd0, redirect_o}, {31'd0, tk});
            check("R5 handler address", redirect_pc_o, HANDLER);
            if (tk) begin
                m_epc = pc_of(idx, c);
                m_cause = {25'd0, code_of(idx, c), 2'b00};
                tag = (n > 1) ? "R3 oldest epc" : "R6 epc capture";
            end else begin
                tag = (e != 0) ? "R2 invalid flag ignored" : "R8 epc hold";
            end
            @(posedge clk);
            read_back(tag, "R7 R9 cause word");
        end

        // R1: reset in mid-run clears the registers
        @(negedge clk);
        stg_valid_i = '0;
        stg_exc_i = '0;
        rst_n = 1'b0;
        m_epc = '0;
        m_cause = '0;
        @(posedge clk);
        read_back("R1 epc mid-run reset", "R1 cause mid-run reset");

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule